// File: doc/BRIEF.md
# Interrupt Request Status Flags

This block holds one pending-request flag for each of sixteen external interrupt pins. Each pin passes through a two-stage synchroniser and a per-pin sense stage. A 2-bit mode field selects the sense condition: low level, falling edge, rising edge or both edges. When the selected condition is seen, the pin's flag latches to 1. Each flag, gated by a per-pin enable, drives its own interrupt line, and a summary line requests service when any enabled flag is set.

There are two ways to clear a flag. Software clears it through a simple synchronous register port by writing 0, but only after a read has returned that flag as 1. Hardware clears it when the CPU acknowledges the exception for that pin, or when a transfer controller services the request. Whether each hardware clear takes effect depends on the sense mode and on a per-request keep option. A set condition arriving in the same cycle as any clear wins, so no request is lost.

Top module: `irq_status_top`

## Requirements
- R1: After reset every flag reads 0, `irq_o` is 0 and `irq_any_o` is 0.
- R2: Flag n sits at bit n of `reg_rdata_o`, which always shows the flags. Mode field n is `sense_cfg_i[2n+1:2n]`, with 00 low level, 01 falling edge, 10 rising edge and 11 both edges. The pin is sampled by two synchroniser flops that reset high. A pin change driven before clock edge k makes the flag read 1 after edge k+2.
- R3: A register write never sets a flag. A write of 0 to a flag that has not been armed by a read leaves the flag unchanged.
- R4: A read cycle (`reg_rd_i`) arms every flag that reads 1. A later write with bit n at 0 clears an armed flag n. Every write disarms all flags.
- R5: In any edge mode, `ack_i[n]` clears flag n.
- R6: In low-level mode, `ack_i[n]` clears flag n only when the synchronised pin is high. While the pin is low, the flag stays set.
- R7: `xfer_act_i[n]` clears flag n when `xfer_keep_i[n]` is 0. When `xfer_keep_i[n]` is 1 it has no effect.
- R8: If a set condition and a clear from any source fall in the same cycle, the flag ends up set.
- R9: `irq_o[n]` is flag n AND `irq_en_i[n]`. `irq_any_o` is the OR of `irq_o`. Enables never change the flags.
- R10: An armed flag is disarmed when any source clears it. A later re-set of that flag followed by a write of 0 without a new read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 16 | Asynchronous interrupt request pins |
| sense_cfg_i | input | 32 | Sense mode, 2 bits per pin |
| irq_en_i | input | 16 | Per-pin interrupt enable |
| ack_i | input | 16 | CPU exception acknowledge, per pin |
| xfer_act_i | input | 16 | Transfer controller activated by request n |
| xfer_keep_i | input | 16 | Keep-interrupt option per request |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Flag register contents |
| irq_o | output | 16 | Enabled per-pin interrupt requests |
| irq_any_o | output | 1 | Summary interrupt request |

## Verification
The hazardous overlap is a fresh sense event landing in the same cycle as a clear. The clear can be an acknowledge, a serviced transfer or an armed software write of 0. The bench provokes this in a directed case: it toggles a both-edge pin and raises that pin's acknowledge exactly two edges later, which is the cycle in which the edge event is seen. It then requires the flag to remain set. A long random phase then overlaps pin activity, acknowledges, transfers, reads and writes freely. Its results are compared every cycle against a behavioural model that resolves each collision in favour of the set.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_mode_e;
endpackage

// File: rtl/irq_sense.sv
module irq_sense
  import irq_flag_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_i,
  input  sense_mode_e mode_i,
  output logic        level_o,
  output logic        event_o
);
  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  prev_q;

  generate
    if (SYNC_DEPTH == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= pin_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_DEPTH-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= level_o;

  assign level_o = sync_q[SYNC_DEPTH-1];

  always_comb begin
    unique case (mode_i)
      SENSE_LOW:  event_o = ~level_o;
      SENSE_FALL: event_o = prev_q & ~level_o;
      SENSE_RISE: event_o = ~prev_q & level_o;
      default:    event_o = prev_q ^ level_o;
    endcase
  end

  // R2
  edge_from_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != SENSE_LOW && event_o) |-> (level_o != $past(level_o)));
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, armed_q, flag_d, armed_d, sw_clr;

  assign sw_clr = wr_i & armed_q & ~wbit_i;
  // set dominates every clear source
  assign flag_d = set_i | (flag_q & ~(hw_clr_i | sw_clr));

  always_comb begin
    if (wr_i)      armed_d = 1'b0;
    else if (rd_i) armed_d = armed_q | flag_q;
    else           armed_d = armed_q;
    armed_d = armed_d & flag_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end

  assign flag_o = flag_q;

  // R3
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));
  // R3
  unarmed_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && wr_i && !armed_q && !hw_clr_i) |=> flag_q);
  // R8
  no_lost_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R4
  write_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !armed_q);
  // R10
  armed_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> flag_q);
endmodule

// File: rtl/irq_status_top.sv
module irq_status_top
  import irq_flag_pkg::*;
#(
  parameter int unsigned N_IRQ      = 16,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned CFG_W     = N_IRQ * MODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_pin_i,
  input  logic [CFG_W-1:0] sense_cfg_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] ack_i,
  input  logic [N_IRQ-1:0] xfer_act_i,
  input  logic [N_IRQ-1:0] xfer_keep_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [N_IRQ-1:0] reg_wdata_i,
  output logic [N_IRQ-1:0] reg_rdata_o,
  output logic [N_IRQ-1:0] irq_o,
  output logic             irq_any_o
);
  logic [N_IRQ-1:0] flag, level, sense_ev, hw_clr;

  for (genvar n = 0; n < N_IRQ; n++) begin : g_ch
    sense_mode_e mode;
    assign mode = sense_mode_e'(sense_cfg_i[n*MODE_W +: MODE_W]);

    irq_sense #(.SYNC_DEPTH(SYNC_DEPTH)) u_sense (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (irq_pin_i[n]),
      .mode_i  (mode),
      .level_o (level[n]),
      .event_o (sense_ev[n])
    );

    // level-sensed ack only clears once the pin has returned high
    assign hw_clr[n] = (ack_i[n] & ((mode != SENSE_LOW) | level[n]))
                     | (xfer_act_i[n] & ~xfer_keep_i[n]);

    irq_flag_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (sense_ev[n]),
      .hw_clr_i (hw_clr[n]),
      .rd_i     (reg_rd_i),
      .wr_i     (reg_wr_i),
      .wbit_i   (reg_wdata_i[n]),
      .flag_o   (flag[n])
    );
  end

  assign reg_rdata_o = flag;
  assign irq_o       = flag & irq_en_i;
  assign irq_any_o   = |irq_o;

  // R9
  irq_within_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~reg_rdata_o) == '0);
  // R9
  any_needs_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_any_o |-> ((reg_rdata_o & irq_en_i) != '0));
endmodule

// File: tb/irq_status_top_test.sv
`timescale 1ns/1ps
module irq_status_top_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]   pin, en, ack, xact, keep, wdata, rdata, irq;
  logic [2*N-1:0] cfg;
  logic           rd, wr, any;

  irq_status_top uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pin), .sense_cfg_i(cfg),
    .irq_en_i(en), .ack_i(ack), .xfer_act_i(xact), .xfer_keep_i(keep),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .irq_any_o(any)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [N-1:0] m_flag, m_arm, m_s1, m_s2, m_p, nf, na;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= '0; m_arm <= '0; m_s1 <= '1; m_s2 <= '1; m_p <= '1;
    end else begin
      for (int n = 0; n < N; n++) begin
        bit ev, clr;
        case (cfg[2*n +: 2])
          2'b00:   ev = !m_s2[n];
          2'b01:   ev = m_p[n] && !m_s2[n];
          2'b10:   ev = !m_p[n] && m_s2[n];
          default: ev = m_p[n] != m_s2[n];
        endcase
        clr = (ack[n] && (cfg[2*n +: 2] != 2'b00 || m_s2[n]))
           || (xact[n] && !keep[n])
           || (wr && m_arm[n] && !wdata[n]);
        nf[n] = ev || (m_flag[n] && !clr);
        if (wr)      na[n] = 1'b0;
        else if (rd) na[n] = m_arm[n] || m_flag[n];
        else         na[n] = m_arm[n];
        na[n] = na[n] && nf[n];
      end
      m_flag <= nf; m_arm <= na;
      m_s1 <= pin; m_s2 <= m_s1; m_p <= m_s2;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(rdata == m_flag, cur_req, {16'h0, rdata}, {16'h0, m_flag});
      chk({any, irq} == {|(m_flag & en), m_flag & en}, "R9",
          {15'h0, any, irq}, {15'h0, |(m_flag & en), m_flag & en});
    end
  end

  task automatic tick(input int k = 1);
    repeat (k) begin @(negedge clk); #1; end
  endtask
  task automatic do_read();
    rd = 1'b1; tick(); rd = 1'b0;
  endtask
  task automatic do_write(input logic [N-1:0] d);
    wr = 1'b1; wdata = d; tick(); wr = 1'b0;
  endtask
  task automatic pulse_ack(input int n);
    ack[n] = 1'b1; tick(); ack[n] = 1'b0;
  endtask
  task automatic bits(input logic [N-1:0] mask, input logic [N-1:0] exp, input string req);
    chk((rdata & mask) == exp, req, {16'h0, rdata & mask}, {16'h0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    pin = '1; cfg = 32'h5555_5555; en = '1; ack = '0; xact = '0; keep = '0;
    rd = 0; wr = 0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(rdata == 0 && irq == 0 && !any, "R1", {15'h0, any, rdata}, 32'h0);
    cmp_on = 1'b1;

    cur_req = "R2"; pin[3] = 1'b0; tick(2);
    bits(16'h0008, 16'h0000, "R2 not yet");
    tick(); bits(16'h0008, 16'h0008, "R2 set at edge k+2");

    cur_req = "R3"; do_write(16'h0000); tick(); bits(16'hFFFF, 16'h0008, "R3 unarmed write");
    do_write(16'hFFFF); tick(); bits(16'hFFFF, 16'h0008, "R3 write one");

    cur_req = "R4"; do_read(); do_write(16'hFFF7); tick(); bits(16'h0008, 16'h0000, "R4 armed clear");

    cur_req = "R5"; pin[3] = 1'b1; tick(4); pin[3] = 1'b0; tick(4);
    bits(16'h0008, 16'h0008, "R5 set");
    pulse_ack(3); tick(); bits(16'h0008, 16'h0000, "R5 ack clears edge flag");

    cur_req = "R6"; cfg[11:10] = 2'b00; pin[5] = 1'b0; tick(4);
    bits(16'h0020, 16'h0020, "R6 level set");
    pulse_ack(5); tick(); bits(16'h0020, 16'h0020, "R6 ack while low");
    pin[5] = 1'b1; tick(4); bits(16'h0020, 16'h0020, "R6 latched");
    pulse_ack(5); tick(); bits(16'h0020, 16'h0000, "R6 ack while high");

    cur_req = "R7"; pin[3] = 1'b1; tick(4); pin[3] = 1'b0; tick(4);
    keep[3] = 1'b1; xact[3] = 1'b1; tick(); xact[3] = 1'b0; tick();
    bits(16'h0008, 16'h0008, "R7 keep holds");
    keep[3] = 1'b0; xact[3] = 1'b1; tick(); xact[3] = 1'b0; tick();
    bits(16'h0008, 16'h0000, "R7 transfer clears");

    cur_req = "R8"; cfg[9:8] = 2'b11; pin[4] = 1'b0; tick(4);
    bits(16'h0010, 16'h0010, "R8 first set");
    pin[4] = 1'b1; tick(2); ack[4] = 1'b1; tick(); ack[4] = 1'b0; tick();
    bits(16'h0010, 16'h0010, "R8 set beats ack");

    cur_req = "R10"; do_read(); pulse_ack(4); tick();
    bits(16'h0010, 16'h0000, "R10 ack clear");
    pin[4] = 1'b0; tick(4); do_write(16'h0000); tick();
    bits(16'h0010, 16'h0010, "R10 stale arm");

    cur_req = "R9"; en = '0; tick();
    chk(irq == 0 && !any && rdata[4], "R9 disabled", {15'h0, any, irq}, 32'h0);
    en = 16'h0010; tick();
    chk(irq == 16'h0010 && any, "R9 enabled", {15'h0, any, irq}, {15'h0, 1'b1, 16'h0010});

    cur_req = "R8 random";
    for (int c = 0; c < 2000; c++) begin
      if (c % 250 == 0) cfg = {$urandom, $urandom} ;
      pin   = pin ^ (16'($urandom) & 16'($urandom));
      ack   = 16'($urandom) & 16'($urandom) & 16'($urandom);
      xact  = 16'($urandom) & 16'($urandom) & 16'($urandom);
      keep  = 16'($urandom);
      en    = 16'($urandom);
      rd    = ($urandom % 4) == 0;
      wr    = ($urandom % 4) == 0;
      wdata = 16'($urandom);
      tick();
    end
    ack = '0; xact = '0; rd = 0; wr = 0; tick(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule